// File: doc/BRIEF.md
# Per-Page Access Permission Checker

This block decides, for every memory access issued by one of up to six bus masters, whether the access may proceed. The decision is indirect. Each page-table entry carries a 4-bit authority index, and that index selects one of sixteen permission domains. Every domain holds a read-block bit and a write-block bit for each master. Software writes these bits through a small register bank. Two domains share each 32-bit word.

A requester presents the master number, the direction and the page's authority index. One cycle later the block returns a response strobe with an allow or deny verdict. A denied access by a master in range also raises that master's bit in a fault vector, for that one cycle only. Address translation, fault capture and interrupt generation sit in neighbouring blocks.

Top module: `perm_chk`

## Requirements
- R1: After reset, domain 0 blocks writes and allows reads for every master, and every other domain allows everything. The word at 0x0B0 reads 0x00000AAA and all other permission words read 0.
- R2: Domain d lives in the word at byte address 0x0B0 + (d/2)*4. The read-block bit for master m is at bit (d&1)*16 + 2*m, and the write-block bit is one position higher. A bit value of 1 blocks the access.
- R3: Bits 12 to 15 and 28 to 31 of every permission word always read 0, and writing them has no effect. Writes to addresses outside 0x0B0..0x0CC, or not word aligned, change nothing, and reads there return 0.
- R4: An access with acc_write=1 (write) or acc_write=0 (read) is denied exactly when the block bit for its master, direction and domain is 1.
- R5: resp_valid is high in exactly the cycle after a cycle with acc_valid high. resp_allow carries the verdict in that cycle and is 0 whenever resp_valid is 0.
- R6: When master m (0 to 5) is denied, fault_vec equals 1<<m in the response cycle. Otherwise fault_vec is 0.
- R7: A register write sampled at one clock edge governs accesses presented in the following cycle. An access presented in the same cycle as the write is judged by the old setting.
- R8: Master numbers 6 and 7 are always denied, and they raise no fault bit.
- R9: A read request (reg_sel=1, reg_we=0) returns the addressed word on reg_rdata one cycle later. reg_rdata holds its value until the next read, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register bus request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after request |
| acc_valid | input | 1 | Access to check |
| acc_master | input | 3 | Master number |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_index | input | 4 | Authority index from the page entry |
| resp_valid | output | 1 | Verdict strobe |
| resp_allow | output | 1 | 1 = access allowed |
| fault_vec | output | 6 | One-hot permission fault per master |

## Verification
The verdict, the fault vector and the read data each come from one register stage. Each is therefore due exactly one cycle after the stimulus that caused it. The bench drives on the falling edge and checks the previous step's expectation at the next falling edge, before it drives new inputs. Its model applies a register write only after it has computed the verdict for the access driven in the same cycle, so the same-cycle and next-cycle effect of a write (R7) is checked on the exact cycle.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;
  // Fixed by the packing: two domains per 32-bit word, one half each.
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  function automatic logic [WORD_W-1:0] word_valid_mask(int unsigned nmast);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int unsigned m = 0; m < nmast; m++) begin
      v[2*m]            = 1'b1;
      v[2*m+1]          = 1'b1;
      v[HALF_W+2*m]     = 1'b1;
      v[HALF_W+2*m+1]   = 1'b1;
    end
    return v;
  endfunction

  // Word 0 holds domain 0 in its low half: writes blocked for every master.
  function automatic logic [WORD_W-1:0] word_reset(int unsigned widx, int unsigned nmast);
    logic [WORD_W-1:0] v;
    v = '0;
    if (widx == 0) begin
      for (int unsigned m = 0; m < nmast; m++) v[2*m+1] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/perm_bank.sv
module perm_bank
  import perm_chk_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned NUM_WORDS   = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BANK_BASE   = 'h0B0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_sel,
  input  logic                               reg_we,
  input  logic [ADDR_W-1:0]                  reg_addr,
  input  logic [WORD_W-1:0]                  reg_wdata,
  output logic [WORD_W-1:0]                  reg_rdata,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   bank_q
);
  localparam logic [WORD_W-1:0] VMASK = word_valid_mask(NUM_MASTERS);

  genvar gw;
  generate
    for (gw = 0; gw < NUM_WORDS; gw++) begin : g_word
      localparam logic [ADDR_W-1:0]  WADDR = ADDR_W'(BANK_BASE + 4*gw);
      localparam logic [WORD_W-1:0]  RVAL  = word_reset(gw, NUM_MASTERS);
      logic              wr_hit;
      logic [WORD_W-1:0] word_d;

      always_comb begin
        wr_hit = reg_sel && reg_we && (reg_addr == WADDR);
        word_d = reg_wdata & VMASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bank_q[gw] <= RVAL;
        else if (wr_hit) bank_q[gw] <= word_d;
      end
    end
  endgenerate

  logic              rd_req;
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    rd_req  = reg_sel && !reg_we;
    rd_word = '0;
    for (int unsigned w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr == ADDR_W'(BANK_BASE + 4*w)) rd_word = bank_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (rd_req) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/perm_lookup.sv
module perm_lookup
  import perm_chk_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned MID_W       = 3,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned NUM_WORDS   = 8
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q,
  input  logic [MID_W-1:0]                 acc_master,
  input  logic                             acc_write,
  input  logic [IDX_W-1:0]                 acc_index,
  output logic                             deny,
  output logic                             in_range
);
  localparam int unsigned BP_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word;
  logic [BP_W-1:0]   bpos;

  always_comb begin
    in_range = ({1'b0, acc_master} < (MID_W+1)'(NUM_MASTERS));
    word     = bank_q[acc_index[IDX_W-1:1]];
    bpos     = (acc_index[0] ? BP_W'(HALF_W) : '0) + BP_W'({acc_master, acc_write});
    deny     = in_range ? word[bpos] : 1'b1;
  end
endmodule

// File: rtl/perm_resp.sv
module perm_resp #(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned MID_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic [MID_W-1:0]       acc_master,
  input  logic                   deny,
  input  logic                   in_range,
  output logic                   resp_valid,
  output logic                   resp_allow,
  output logic [NUM_MASTERS-1:0] fault_vec
);
  logic                   valid_d;
  logic                   allow_d;
  logic [NUM_MASTERS-1:0] fault_d;

  always_comb begin
    valid_d = acc_valid;
    allow_d = acc_valid && !deny;
    fault_d = '0;
    if (acc_valid && deny && in_range) fault_d = NUM_MASTERS'(1) << acc_master;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      fault_vec  <= '0;
    end else begin
      resp_valid <= valid_d;
      resp_allow <= allow_d;
      fault_vec  <= fault_d;
    end
  end
endmodule

// File: rtl/perm_chk.sv
module perm_chk
  import perm_chk_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned MID_W       = 3,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BANK_BASE   = 'h0B0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_sel,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   acc_valid,
  input  logic [MID_W-1:0]       acc_master,
  input  logic                   acc_write,
  input  logic [IDX_W-1:0]       acc_index,
  output logic                   resp_valid,
  output logic                   resp_allow,
  output logic [NUM_MASTERS-1:0] fault_vec
);
  localparam int unsigned NUM_DOMAINS = 2**IDX_W;
  localparam int unsigned NUM_WORDS   = NUM_DOMAINS / 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q;
  logic deny;
  logic in_range;

  perm_bank #(
    .NUM_MASTERS(NUM_MASTERS), .NUM_WORDS(NUM_WORDS),
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_int_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bank_q(bank_q)
  );

  perm_lookup #(
    .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W), .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)
  ) u_lookup (
    .bank_q(bank_q), .acc_master(acc_master), .acc_write(acc_write),
    .acc_index(acc_index), .deny(deny), .in_range(in_range)
  );

  perm_resp #(
    .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)
  ) u_resp (
    .clk(clk), .rst_n(rst_int_n), .acc_valid(acc_valid), .acc_master(acc_master),
    .deny(deny), .in_range(in_range), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .fault_vec(fault_vec)
  );
endmodule

// File: rtl/perm_chk_sva.sv
module perm_chk_sva #(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned MID_W       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic [MID_W-1:0]       acc_master,
  input logic                   resp_valid,
  input logic                   resp_allow,
  input logic [NUM_MASTERS-1:0] fault_vec
);
  localparam logic [NUM_MASTERS-1:0] ONE_M = NUM_MASTERS'(1);
  localparam logic [MID_W:0]         NM_W  = (MID_W+1)'(NUM_MASTERS);

  a_r5_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == $past(acc_valid));

  a_r5_no_allow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!resp_allow && fault_vec == '0));

  a_r6_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_vec));

  a_r6_fault_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vec != '0) |-> (resp_valid && !resp_allow));

  a_r6_fault_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_allow && ({1'b0, $past(acc_master)} < NM_W))
      |-> (fault_vec == (ONE_M << $past(acc_master))));

  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !({1'b0, $past(acc_master)} < NM_W))
      |-> (!resp_allow && fault_vec == '0));
endmodule

bind perm_chk perm_chk_sva #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_sva (
  .clk(clk), .rst_n(rst_int_n), .acc_valid(acc_valid), .acc_master(acc_master),
  .resp_valid(resp_valid), .resp_allow(resp_allow), .fault_vec(fault_vec)
);

// File: tb/perm_chk_test.sv
`timescale 1ns/1ps
module perm_chk_test;
  localparam logic [31:0] VMASK = 32'h0FFF_0FFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_we, acc_valid, acc_write;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  acc_master;
  logic [3:0]  acc_index;
  logic        resp_valid, resp_allow;
  logic [5:0]  fault_vec;

  always #10 clk = ~clk;

  perm_chk uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_master(acc_master), .acc_write(acc_write),
    .acc_index(acc_index), .resp_valid(resp_valid), .resp_allow(resp_allow),
    .fault_vec(fault_vec)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [31:0] mdl [8];
  string       ptag;
  logic        p_valid, p_allow, p_rd;
  logic [5:0]  p_fault;
  logic [31:0] p_rdv;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
    end
  endtask

  function automatic bit in_bank(logic [11:0] a);
    return (a >= 12'h0B0) && (a <= 12'h0CC) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] mdl_read(logic [11:0] a);
    return in_bank(a) ? mdl[(a - 12'h0B0) >> 2] : 32'h0;
  endfunction

  function automatic bit mdl_deny(logic [2:0] m, bit wr, logic [3:0] ix);
    logic [31:0] w;
    if (m > 3'd5) return 1'b1;
    w = mdl[ix >> 1];
    return w[(ix[0] ? 16 : 0) + 2*m + wr];
  endfunction

  task automatic step(string tag, bit av, logic [2:0] m, bit wr, logic [3:0] ix,
                      bit rs, bit rwe, logic [11:0] ra, logic [31:0] rd);
    bit dn;
    chk({ptag, " R5 resp_valid"}, 32'(resp_valid), 32'(p_valid));
    chk({ptag, " R4 resp_allow"}, 32'(resp_allow), 32'(p_allow));
    chk({ptag, " R6 fault_vec"},  32'(fault_vec),  32'(p_fault));
    if (p_rd) chk({ptag, " R9 reg_rdata"}, reg_rdata, p_rdv);
    acc_valid = av; acc_master = m; acc_write = wr; acc_index = ix;
    reg_sel = rs; reg_we = rwe; reg_addr = ra; reg_wdata = rd;
    dn      = mdl_deny(m, wr, ix);
    ptag    = tag;
    p_valid = av;
    p_allow = av && !dn;
    p_fault = (av && dn && m <= 3'd5) ? (6'd1 << m) : 6'd0;
    p_rd    = rs && !rwe;
    p_rdv   = mdl_read(ra);
    if (rs && rwe && in_bank(ra)) mdl[(ra - 12'h0B0) >> 2] = rd & VMASK;
    @(negedge clk);
  endtask

  task automatic acc(string tag, logic [2:0] m, bit wr, logic [3:0] ix);
    step(tag, 1, m, wr, ix, 0, 0, 12'h0, 32'h0);
  endtask
  task automatic rwr(string tag, logic [11:0] a, logic [31:0] d);
    step(tag, 0, 0, 0, 0, 1, 1, a, d);
  endtask
  task automatic rrd(string tag, logic [11:0] a);
    step(tag, 0, 0, 0, 0, 1, 0, a, 32'h0);
  endtask
  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 12'h0, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd24681));
    rst_n = 0; reg_sel = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    acc_valid = 0; acc_master = 0; acc_write = 0; acc_index = 0;
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    mdl[0]  = 32'h0000_0AAA;
    ptag    = "R1 reset";
    p_valid = 0; p_allow = 0; p_fault = 0; p_rd = 1; p_rdv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset contents of every word
    for (int w = 0; w < 8; w++) rrd("R1", 12'(12'h0B0 + 4*w));
    // R1: domain 0 writes denied, reads allowed, for each master
    for (int m = 0; m < 6; m++) begin
      acc("R1", 3'(m), 1, 4'd0);
      acc("R1", 3'(m), 0, 4'd0);
    end
    acc("R1", 3'd3, 1, 4'd5);
    // R2: domain 7, master 2, read-block at bit 20
    rwr("R2", 12'h0BC, 32'h0010_0000);
    acc("R2", 3'd2, 0, 4'd7);
    acc("R2", 3'd2, 1, 4'd7);
    acc("R2", 3'd2, 0, 4'd6);
    acc("R2", 3'd1, 0, 4'd7);
    rrd("R2", 12'h0BC);
    // R3: reserved bits and out-of-bank addresses
    rwr("R3", 12'h0B4, 32'hFFFF_FFFF);
    rrd("R3", 12'h0B4);
    rwr("R3", 12'h040, 32'hFFFF_FFFF);
    rwr("R3", 12'h0D0, 32'hFFFF_FFFF);
    rwr("R3", 12'h0B6, 32'hFFFF_FFFF);
    for (int w = 0; w < 8; w++) rrd("R3", 12'(12'h0B0 + 4*w));
    rrd("R3", 12'h0D0);
    acc("R3", 3'd5, 1, 4'd2);
    acc("R3", 3'd0, 0, 4'd14);
    // R7: write and access in the same cycle use the old setting
    step("R7", 1, 3'd1, 1, 4'd0, 1, 1, 12'h0B0, 32'h0);
    acc("R7", 3'd1, 1, 4'd0);
    step("R7", 1, 3'd4, 0, 4'd3, 1, 1, 12'h0B4, 32'h0000_0100);
    acc("R7", 3'd4, 0, 4'd3);
    // R8: out-of-range masters
    acc("R8", 3'd6, 0, 4'd2);
    acc("R8", 3'd7, 1, 4'd9);
    idle("R5");
    // R9: read data holds between reads
    rrd("R9", 12'h0BC);
    idle("R9");
    chk("R9 hold", reg_rdata, mdl[3]);

    // Constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit          av, wr, rs, rwe;
      logic [2:0]  m;
      logic [3:0]  ix;
      logic [11:0] ra;
      logic [31:0] rd;
      av  = ($urandom % 4) != 0;
      m   = (($urandom % 8) == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
      wr  = $urandom % 2;
      ix  = 4'($urandom);
      rs  = ($urandom % 3) == 0;
      rwe = $urandom % 2;
      ra  = (($urandom % 10) == 0) ? 12'($urandom) : 12'(12'h0B0 + 4*($urandom % 8));
      rd  = $urandom & $urandom;
      step("R4", av, m, wr, ix, rs, rwe, ra, rd);
    end
    idle("R5");
    idle("R5");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule